// File: doc/BRIEF.md
# Selective Broadcast Endpoint Sender

The block turns a software activation into a burst of endpoint messages. An activation names a sender slot and a 6-bit set index. The block computes where that 512-byte descriptor set lives in memory and reads only the first 64-byte descriptor of the set over a plain request/response memory port. It checks the descriptor header and then walks the 256-bit distribution vector held in the descriptor. It issues one message for each set bit, with the destination node ID formed by adding the bit index to the header's base node ID.

Each message carries a 144-bit entry that is rebuilt from pieces of the descriptor. Twelve payload bytes come first. Three header bytes follow, then a byte left zero for a vector the destination fills in, then two more header bytes. Each sender slot has a 2-bit activation status word that can be read directly. The word leaves the active code only when the messages and their acknowledgements balance, or when a timeout pulse for that slot arrives.

Top module: `bsu_sender`

## Requirements
- R1: An accepted activation for set index n reads exactly 64/(MEM_W/8) memory words, at addresses base + n*512 + k*(MEM_W/8) for k = 0,1,... in ascending order. No other descriptor of the set is read.
- R2: One message is issued for each 1 bit of the distribution vector (descriptor bytes 0x00-0x1F, bit i = descriptor bit i), lowest index first. Each message carries destination = header bits 20:6 + i, modulo 2^15.
- R3: The message entry is {header bits 56:41 in bits 143:128, 8'h00 in bits 127:120, header bits 81:58 in bits 119:96, descriptor payload bytes 0x20-0x2B in bits 95:0}. The header is descriptor bits 511:384.
- R4: A descriptor whose header bit 105 is 1, whose header bit 106 is 1, or whose header bits 28:21 differ from 8'h38 issues no message. It pulses fmt_err_o for one cycle, and the sender status returns to 0.
- R5: Status codes in status_o[2s+1:2s] are 0 idle, 1 active, 2 destination timeout and 3 source timeout. An accepted activation sets the slot to 1, including from 2 or 3.
- R6: An active slot returns to 0 only after every message has been accepted and an equal number of ack_i pulses for that slot has been counted.
- R7: A dst_tmo_i pulse for an active slot sets it to 2, and a src_tmo_i pulse sets it to 3. No further message for that activation is offered. Later ack pulses leave the code unchanged.
- R8: An activation naming a slot whose status is 1 is ignored. It causes no memory read, no message and no status change, and it pulses busy_err_o.
- R9: While msg_ready_i is low, a pending message stays valid with unchanged fields. With msg_ready_i high, consecutive set bits leave in consecutive cycles.
- R10: msg_swack_o carries header bit 89 of the active descriptor.
- R11: After reset every status is 0, act_ready_o is 1, and mem_req_o and msg_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| act_valid_i | input | 1 | activation request |
| act_ready_o | output | 1 | engine free to take an activation |
| act_sender_i | input | SND_W | sender slot of the activation |
| act_set_i | input | 6 | descriptor set index |
| desc_base_i | input | ADDR_W | byte address of set 0 |
| mem_req_o | output | 1 | memory read request |
| mem_addr_o | output | ADDR_W | memory read byte address |
| mem_rvalid_i | input | 1 | read data valid |
| mem_rdata_i | input | MEM_W | read data, lowest address in low bits |
| msg_valid_o | output | 1 | message offered |
| msg_ready_i | input | 1 | message taken |
| msg_dest_o | output | 15 | destination node ID |
| msg_data_o | output | 144 | repacked entry |
| msg_sender_o | output | SND_W | sender slot of the message |
| msg_swack_o | output | 1 | software-acknowledge request |
| ack_i | input | NUM_SND | per-slot acknowledge pulse |
| dst_tmo_i | input | NUM_SND | per-slot destination timeout pulse |
| src_tmo_i | input | NUM_SND | per-slot source timeout pulse |
| status_o | output | 2*NUM_SND | packed per-slot status |
| busy_err_o | output | 1 | activation refused, slot busy |
| fmt_err_o | output | 1 | descriptor refused |

## Verification
A corrupted pending-acknowledge counter shows at status_o. The slot either drops to idle one cycle after the last message leaves with acks still owed, or it never leaves the active code after the final ack. A scan register that clears the wrong bit shows as a repeated or skipped destination on the next message cycle. A stale engine state shows as act_ready_o staying low, or as messages still offered in the cycle after a timeout pulse. The bench records every message with its cycle number, so ordering and gap errors show up within the burst.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACTIVE  = 2'd1,
      ST_DST_TMO = 2'd2,
      ST_SRC_TMO = 2'd3
   } act_st_e;

   localparam int DESC_BITS = 512;
   localparam int VEC_BITS  = 256;
   localparam int PAY_LSB   = 256;
   localparam int HDR_LSB   = 384;
   localparam int NODE_W    = 15;
   localparam int ENTRY_W   = 144;
   localparam int SET_SHIFT = 9;

   localparam logic [7:0] ENDPOINT_CMD = 8'h38;

   // header bit positions (relative to header bit 0)
   localparam int H_NODE_LSB = 6;
   localparam int H_CMD_LSB  = 21;
   localparam int H_SWACK    = 89;
   localparam int H_MLEVEL   = 105;
   localparam int H_CHAIN    = 106;

   // rebuild the queue entry from the descriptor
   function automatic logic [ENTRY_W-1:0] repack(input logic [DESC_BITS-1:0] d);
      logic [127:0] h;
      h = d[HDR_LSB +: 128];
      return {h[56:41], 8'h00, h[81:58], d[PAY_LSB +: 96]};
   endfunction

endpackage

// File: rtl/bsu_fetch.sv
module bsu_fetch
   import bsu_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int MEM_W  = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [5:0]           set_idx_i,
   input  logic [ADDR_W-1:0]    base_i,
   output logic                 mem_req_o,
   output logic [ADDR_W-1:0]    mem_addr_o,
   input  logic                 mem_rvalid_i,
   input  logic [MEM_W-1:0]     mem_rdata_i,
   output logic                 desc_valid_o,
   output logic [DESC_BITS-1:0] desc_o
);
   localparam int MEM_BYTES = MEM_W / 8;
   localparam int BEATS     = DESC_BITS / MEM_W;
   localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (MEM_W != 64 && MEM_W != 128 && MEM_W != 256 && MEM_W != 512) begin : g_bad_mem_w
      $error("bsu_fetch: MEM_W must be 64, 128, 256 or 512");
   end
   if (ADDR_W < 16) begin : g_bad_addr_w
      $error("bsu_fetch: ADDR_W too small");
   end

   logic                 busy_q;
   logic                 wait_q;
   logic [BEAT_W-1:0]    beat_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [DESC_BITS-1:0] desc_q;
   logic                 done_q;
   logic                 last_beat;

   if (BEATS > 1) begin : g_multi
      assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
   end else begin : g_single
      assign last_beat = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wait_q <= 1'b0;
         beat_q <= '0;
         addr_q <= '0;
         desc_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            busy_q <= 1'b1;
            wait_q <= 1'b0;
            beat_q <= '0;
            addr_q <= base_i + (ADDR_W'(set_idx_i) << SET_SHIFT);
         end else if (busy_q) begin
            if (!wait_q) begin
               wait_q <= 1'b1;
            end else if (mem_rvalid_i) begin
               desc_q[int'(beat_q)*MEM_W +: MEM_W] <= mem_rdata_i;
               wait_q <= 1'b0;
               if (last_beat) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
         end
      end
   end

   assign mem_req_o    = busy_q && !wait_q;
   assign mem_addr_o   = addr_q + ADDR_W'(beat_q) * ADDR_W'(MEM_BYTES);
   assign desc_valid_o = done_q;
   assign desc_o       = desc_q;

endmodule

// File: rtl/bsu_scan.sv
module bsu_scan
   import bsu_pkg::*;
#(
   parameter int VEC_W = VEC_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic [NODE_W-1:0] node_base_i,
   input  logic              clear_i,
   input  logic              take_i,
   output logic              valid_o,
   output logic [NODE_W-1:0] dest_o
);
   localparam int IDX_W = $clog2(VEC_W);

   if (VEC_W < 2) begin : g_bad_vec
      $error("bsu_scan: VEC_W must be at least 2");
   end

   logic [VEC_W-1:0]  vec_q;
   logic [NODE_W-1:0] base_q;
   logic [IDX_W-1:0]  idx;

   // lowest set bit wins
   always_comb begin
      idx = '0;
      for (int i = VEC_W - 1; i >= 0; i--) begin
         if (vec_q[i]) idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         base_q <= '0;
      end else if (clear_i) begin
         vec_q <= '0;
      end else if (load_i) begin
         vec_q  <= vec_i;
         base_q <= node_base_i;
      end else if (take_i) begin
         vec_q <= vec_q & (vec_q - 1'b1);
      end
   end

   assign valid_o = |vec_q;
   assign dest_o  = base_q + NODE_W'(idx);

endmodule

// File: rtl/bsu_status.sv
module bsu_status
   import bsu_pkg::*;
#(
   parameter int NUM_SND = 4,
   parameter int CNT_W   = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SND-1:0]   start_i,
   input  logic [NUM_SND-1:0]   serving_i,
   input  logic [NUM_SND-1:0]   sent_i,
   input  logic [NUM_SND-1:0]   ack_i,
   input  logic [NUM_SND-1:0]   dtmo_i,
   input  logic [NUM_SND-1:0]   stmo_i,
   output logic [2*NUM_SND-1:0] status_o
);

   for (genvar s = 0; s < NUM_SND; s++) begin : g_slot
      act_st_e          st_q;
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_sum;
      logic [CNT_W-1:0] cnt_nx;

      always_comb begin
         cnt_sum = cnt_q + CNT_W'(sent_i[s]);
         cnt_nx  = cnt_sum;
         if (ack_i[s] && cnt_sum != '0) cnt_nx = cnt_sum - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
         end else if (start_i[s]) begin
            st_q  <= ST_ACTIVE;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_nx;
            if (st_q == ST_ACTIVE) begin
               if (dtmo_i[s])                          st_q <= ST_DST_TMO;
               else if (stmo_i[s])                     st_q <= ST_SRC_TMO;
               else if (!serving_i[s] && cnt_nx == '0) st_q <= ST_IDLE;
            end
         end
      end

      assign status_o[2*s +: 2] = st_q;
   end

endmodule

// File: rtl/bsu_sender.sv
module bsu_sender
   import bsu_pkg::*;
#(
   parameter int NUM_SND = 4,
   parameter int ADDR_W  = 48,
   parameter int MEM_W   = 128,
   localparam int SND_W  = (NUM_SND > 1) ? $clog2(NUM_SND) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 act_valid_i,
   output logic                 act_ready_o,
   input  logic [SND_W-1:0]     act_sender_i,
   input  logic [5:0]           act_set_i,
   input  logic [ADDR_W-1:0]    desc_base_i,
   output logic                 mem_req_o,
   output logic [ADDR_W-1:0]    mem_addr_o,
   input  logic                 mem_rvalid_i,
   input  logic [MEM_W-1:0]     mem_rdata_i,
   output logic                 msg_valid_o,
   input  logic                 msg_ready_i,
   output logic [NODE_W-1:0]    msg_dest_o,
   output logic [ENTRY_W-1:0]   msg_data_o,
   output logic [SND_W-1:0]     msg_sender_o,
   output logic                 msg_swack_o,
   input  logic [NUM_SND-1:0]   ack_i,
   input  logic [NUM_SND-1:0]   dst_tmo_i,
   input  logic [NUM_SND-1:0]   src_tmo_i,
   output logic [2*NUM_SND-1:0] status_o,
   output logic                 busy_err_o,
   output logic                 fmt_err_o
);
   localparam int CNT_W = $clog2(VEC_BITS) + 1;

   if (NUM_SND < 1 || NUM_SND > 32) begin : g_bad_snd
      $error("bsu_sender: NUM_SND must be 1..32 (one status word)");
   end

   typedef enum logic [1:0] {ENG_IDLE, ENG_FETCH, ENG_SEND} eng_e;

   eng_e                 eng_q;
   logic [SND_W-1:0]     cur_q;
   logic                 swack_q;
   logic [ENTRY_W-1:0]   data_q;
   logic                 busy_err_q;
   logic                 fmt_err_q;

   logic                 act_fire;
   logic                 accept;
   logic                 refuse;
   logic [1:0]           sel_st;
   logic [1:0]           cur_st;
   logic                 cur_live;
   logic                 desc_valid;
   logic [DESC_BITS-1:0] desc;
   logic [127:0]         hdr;
   logic                 hdr_ok;
   logic                 scan_load;
   logic                 scan_clear;
   logic                 scan_valid;
   logic                 take;
   logic [NODE_W-1:0]    scan_dest;
   logic [NUM_SND-1:0]   start_v;
   logic [NUM_SND-1:0]   serve_v;
   logic [NUM_SND-1:0]   sent_v;

   assign act_ready_o = (eng_q == ENG_IDLE);
   assign act_fire    = act_valid_i && act_ready_o;
   assign sel_st      = status_o[{act_sender_i, 1'b0} +: 2];
   assign cur_st      = status_o[{cur_q, 1'b0} +: 2];
   assign cur_live    = (cur_st == ST_ACTIVE);
   assign accept      = act_fire && (sel_st != ST_ACTIVE);
   assign refuse      = act_fire && (sel_st == ST_ACTIVE);

   assign hdr    = desc[HDR_LSB +: 128];
   assign hdr_ok = !hdr[H_MLEVEL] && !hdr[H_CHAIN] &&
                   (hdr[H_CMD_LSB +: 8] == ENDPOINT_CMD);

   assign scan_load  = (eng_q == ENG_FETCH) && desc_valid && cur_live && hdr_ok;
   assign scan_clear = (eng_q == ENG_SEND) && !cur_live;
   assign take       = msg_valid_o && msg_ready_i;

   bsu_fetch #(
      .ADDR_W (ADDR_W),
      .MEM_W  (MEM_W)
   ) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (accept),
      .set_idx_i    (act_set_i),
      .base_i       (desc_base_i),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_rvalid_i (mem_rvalid_i),
      .mem_rdata_i  (mem_rdata_i),
      .desc_valid_o (desc_valid),
      .desc_o       (desc)
   );

   bsu_scan #(
      .VEC_W (VEC_BITS)
   ) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (scan_load),
      .vec_i       (desc[VEC_BITS-1:0]),
      .node_base_i (hdr[H_NODE_LSB +: NODE_W]),
      .clear_i     (scan_clear),
      .take_i      (take),
      .valid_o     (scan_valid),
      .dest_o      (scan_dest)
   );

   always_comb begin
      start_v = '0;
      serve_v = '0;
      sent_v  = '0;
      if (accept)              start_v[act_sender_i] = 1'b1;
      if (eng_q != ENG_IDLE)   serve_v[cur_q]        = 1'b1;
      if (take)                sent_v[cur_q]         = 1'b1;
   end

   bsu_status #(
      .NUM_SND (NUM_SND),
      .CNT_W   (CNT_W)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_v),
      .serving_i (serve_v),
      .sent_i    (sent_v),
      .ack_i     (ack_i),
      .dtmo_i    (dst_tmo_i),
      .stmo_i    (src_tmo_i),
      .status_o  (status_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_q      <= ENG_IDLE;
         cur_q      <= '0;
         swack_q    <= 1'b0;
         data_q     <= '0;
         busy_err_q <= 1'b0;
         fmt_err_q  <= 1'b0;
      end else begin
         busy_err_q <= refuse;
         fmt_err_q  <= 1'b0;
         unique case (eng_q)
            ENG_IDLE: begin
               if (accept) begin
                  eng_q <= ENG_FETCH;
                  cur_q <= act_sender_i;
               end
            end
            ENG_FETCH: begin
               if (desc_valid) begin
                  if (!cur_live) begin
                     eng_q <= ENG_IDLE;
                  end else if (!hdr_ok) begin
                     eng_q     <= ENG_IDLE;
                     fmt_err_q <= 1'b1;
                  end else begin
                     eng_q   <= ENG_SEND;
                     swack_q <= hdr[H_SWACK];
                     data_q  <= repack(desc);
                  end
               end
            end
            ENG_SEND: begin
               if (!cur_live || !scan_valid) eng_q <= ENG_IDLE;
            end
            default: eng_q <= ENG_IDLE;
         endcase
      end
   end

   assign msg_valid_o  = (eng_q == ENG_SEND) && scan_valid && cur_live;
   assign msg_dest_o   = scan_dest;
   assign msg_data_o   = data_q;
   assign msg_sender_o = cur_q;
   assign msg_swack_o  = swack_q;
   assign busy_err_o   = busy_err_q;
   assign fmt_err_o    = fmt_err_q;

endmodule

// File: rtl/bsu_sender_chk.sv
module bsu_sender_chk
   import bsu_pkg::*;
#(
   parameter int NUM_SND = 4,
   localparam int SND_W  = (NUM_SND > 1) ? $clog2(NUM_SND) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 act_valid_i,
   input logic                 act_ready_o,
   input logic [SND_W-1:0]     act_sender_i,
   input logic                 mem_req_o,
   input logic                 msg_valid_o,
   input logic                 msg_ready_i,
   input logic [NODE_W-1:0]    msg_dest_o,
   input logic [ENTRY_W-1:0]   msg_data_o,
   input logic [SND_W-1:0]     msg_sender_o,
   input logic [NUM_SND-1:0]   dst_tmo_i,
   input logic [NUM_SND-1:0]   src_tmo_i,
   input logic [2*NUM_SND-1:0] status_o,
   input logic                 busy_err_o,
   input logic                 fmt_err_o
);

   // R9
   hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && !msg_ready_i && dst_tmo_i == '0 && src_tmo_i == '0)
      |=> (msg_valid_o && $stable(msg_dest_o) && $stable(msg_data_o)));

   // R8
   busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid_i && act_ready_o && status_o[{act_sender_i, 1'b0} +: 2] == 2'd1)
      |=> busy_err_o);

   // R1
   req_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !act_ready_o);

   // R4
   fmt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err_o |-> !msg_valid_o);

   // R7
   msg_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o |-> (status_o[{msg_sender_o, 1'b0} +: 2] == 2'd1));

   for (genvar s = 0; s < NUM_SND; s++) begin : g_slot_chk
      // R5
      idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(status_o[2*s +: 2]) == 2'd0 && status_o[2*s +: 2] != 2'd0)
         |-> (status_o[2*s +: 2] == 2'd1));
   end

endmodule

bind bsu_sender bsu_sender_chk #(.NUM_SND(NUM_SND)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .act_valid_i  (act_valid_i),
   .act_ready_o  (act_ready_o),
   .act_sender_i (act_sender_i),
   .mem_req_o    (mem_req_o),
   .msg_valid_o  (msg_valid_o),
   .msg_ready_i  (msg_ready_i),
   .msg_dest_o   (msg_dest_o),
   .msg_data_o   (msg_data_o),
   .msg_sender_o (msg_sender_o),
   .dst_tmo_i    (dst_tmo_i),
   .src_tmo_i    (src_tmo_i),
   .status_o     (status_o),
   .busy_err_o   (busy_err_o),
   .fmt_err_o    (fmt_err_o)
);

// File: tb/bsu_sender_bench.sv
`timescale 1ns/1ps
module bsu_sender_bench;
   localparam int NUM_SND = 4;
   localparam int SND_W   = 2;
   localparam int ADDR_W  = 48;
   localparam int MEM_W   = 128;
   localparam logic [ADDR_W-1:0] BASE = 48'h0000_1234_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic                 act_valid_i = 1'b0;
   logic                 act_ready_o;
   logic [SND_W-1:0]     act_sender_i = '0;
   logic [5:0]           act_set_i = '0;
   logic                 mem_req_o;
   logic [ADDR_W-1:0]    mem_addr_o;
   logic                 mem_rvalid_i = 1'b0;
   logic [MEM_W-1:0]     mem_rdata_i = '0;
   logic                 msg_valid_o;
   logic                 msg_ready_i = 1'b0;
   logic [14:0]          msg_dest_o;
   logic [143:0]         msg_data_o;
   logic [SND_W-1:0]     msg_sender_o;
   logic                 msg_swack_o;
   logic [NUM_SND-1:0]   ack_i = '0;
   logic [NUM_SND-1:0]   dst_tmo_i = '0;
   logic [NUM_SND-1:0]   src_tmo_i = '0;
   logic [2*NUM_SND-1:0] status_o;
   logic                 busy_err_o;
   logic                 fmt_err_o;

   bsu_sender #(.NUM_SND(NUM_SND), .ADDR_W(ADDR_W), .MEM_W(MEM_W)) u_bsu_sender (
      .clk(clk), .rst_n(rst_n),
      .act_valid_i(act_valid_i), .act_ready_o(act_ready_o),
      .act_sender_i(act_sender_i), .act_set_i(act_set_i), .desc_base_i(BASE),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
      .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
      .msg_dest_o(msg_dest_o), .msg_data_o(msg_data_o),
      .msg_sender_o(msg_sender_o), .msg_swack_o(msg_swack_o),
      .ack_i(ack_i), .dst_tmo_i(dst_tmo_i), .src_tmo_i(src_tmo_i),
      .status_o(status_o), .busy_err_o(busy_err_o), .fmt_err_o(fmt_err_o)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0, rd_cnt = 0, bad_rd = 0, busy_cnt = 0, fmt_cnt = 0;
   logic [5:0]   exp_set = '0;
   logic [511:0] dmem [64];

   logic [14:0]  got_dest [64];
   logic [143:0] got_data [64];
   logic         got_sw   [64];
   logic [1:0]   got_snd  [64];
   int           got_cyc  [64];
   int           n_got;

   // memory model and pulse monitors
   always @(posedge clk) begin
      logic [ADDR_W-1:0] off;
      cyc++;
      mem_rvalid_i <= 1'b0;
      if (busy_err_o) busy_cnt++;
      if (fmt_err_o)  fmt_cnt++;
      if (mem_req_o) begin
         off = mem_addr_o - BASE;
         rd_cnt++;
         if (off[8:0] >= 9'd64 || off[3:0] != 4'd0 || off[14:9] != exp_set ||
             off[ADDR_W-1:15] != '0 || off[5:4] != 2'(rd_cnt - 1)) bad_rd++;
         mem_rvalid_i <= 1'b1;
         mem_rdata_i  <= dmem[off[14:9]][int'(off[5:4])*128 +: 128];
      end
   end

   function automatic logic [511:0] mk_desc(input logic [255:0] vec, input logic [14:0] nb,
         input logic [7:0] cmd, input logic ml, input logic ch, input logic sw,
         input logic [95:0] pay, input logic [23:0] c3, input logic [15:0] b2);
      logic [511:0] d;
      logic [127:0] h;
      h = '0;
      h[20:6] = nb; h[28:21] = cmd; h[56:41] = b2; h[81:58] = c3;
      h[89] = sw; h[105] = ml; h[106] = ch;
      d = '0;
      d[255:0] = vec; d[351:256] = pay; d[511:384] = h;
      return d;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [143:0] act,
                      input logic [143:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] st(input int s);
      return status_o[2*s +: 2];
   endfunction

   task automatic activate(input int s, input int set);
      @(negedge clk);
      exp_set = 6'(set);
      rd_cnt = 0;
      act_valid_i = 1'b1; act_sender_i = SND_W'(s); act_set_i = 6'(set);
      while (!act_ready_o) @(negedge clk);
      @(negedge clk);
      act_valid_i = 1'b0;
   endtask

   task automatic collect();
      int idle = 0;
      n_got = 0;
      msg_ready_i = 1'b1;
      for (int k = 0; k < 600 && idle < 3; k++) begin
         if (msg_valid_o) begin
            got_dest[n_got] = msg_dest_o; got_data[n_got] = msg_data_o;
            got_sw[n_got] = msg_swack_o; got_snd[n_got] = msg_sender_o;
            got_cyc[n_got] = cyc; n_got++;
            idle = 0;
         end else if (act_ready_o) idle++;
         @(negedge clk);
      end
      msg_ready_i = 1'b0;
   endtask

   task automatic wait_valid();
      for (int k = 0; k < 200 && !msg_valid_o; k++) @(negedge clk);
   endtask

   task automatic pulse_ack(input int s);
      @(negedge clk); ack_i[s] = 1'b1;
      @(negedge clk); ack_i = '0;
   endtask

   task automatic t_reset();
      chk(status_o == '0, "R11 status", 144'(status_o), 0);
      chk(act_ready_o == 1'b1, "R11 act_ready", 144'(act_ready_o), 1);
      chk(!msg_valid_o && !mem_req_o, "R11 idle outputs", 144'({msg_valid_o, mem_req_o}), 0);
   endtask

   task automatic t_basic();
      logic [255:0] v = '0;
      logic [143:0] exp;
      v[0] = 1; v[3] = 1; v[255] = 1;
      dmem[5] = mk_desc(v, 15'd100, 8'h38, 0, 0, 1, 96'hA1A2A3A4_B1B2B3B4_C1C2C3C4,
                        24'hABCDEF, 16'h5A3C);
      exp = {16'h5A3C, 8'h00, 24'hABCDEF, 96'hA1A2A3A4_B1B2B3B4_C1C2C3C4};
      activate(1, 5);
      collect();
      chk(n_got == 3, "R2 message count", 144'(n_got), 3);
      chk(got_dest[0] == 15'd100, "R2 dest bit0", 144'(got_dest[0]), 100);
      chk(got_dest[1] == 15'd103, "R2 dest bit3", 144'(got_dest[1]), 103);
      chk(got_dest[2] == 15'd355, "R2 dest bit255", 144'(got_dest[2]), 355);
      chk(got_data[0] == exp && got_data[2] == exp, "R3 entry layout", got_data[0], exp);
      chk(got_sw[0] == 1'b1 && got_snd[0] == 2'd1, "R10 swack/sender",
          144'({got_sw[0], got_snd[0]}), 144'({1'b1, 2'd1}));
      chk(rd_cnt == 4 && bad_rd == 0, "R1 reads", 144'({rd_cnt, bad_rd}), 144'({32'd4, 32'd0}));
      chk(st(1) == 2'd1, "R5 active after send", 144'(st(1)), 1);
      pulse_ack(1); pulse_ack(1);
      chk(st(1) == 2'd1, "R6 acks outstanding", 144'(st(1)), 1);
      pulse_ack(1);
      chk(st(1) == 2'd0, "R6 idle after last ack", 144'(st(1)), 0);
   endtask

   task automatic t_stream();
      logic [255:0] v = '0;
      logic [14:0] d0;
      bit ok = 1;
      v[13:10] = 4'hF;
      dmem[7] = mk_desc(v, 15'd0, 8'h38, 0, 0, 0, 96'h1, 24'h2, 16'h3);
      activate(0, 7);
      wait_valid();
      d0 = msg_dest_o;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (!msg_valid_o || msg_dest_o != d0) ok = 0;
      end
      chk(ok && d0 == 15'd10, "R9 hold under backpressure", 144'(msg_dest_o), 10);
      collect();
      chk(n_got == 4 && got_dest[3] == 15'd13, "R9 burst content", 144'(got_dest[3]), 13);
      chk(got_cyc[3] - got_cyc[0] == 3, "R9 no bubbles", 144'(got_cyc[3] - got_cyc[0]), 3);
      chk(got_sw[0] == 1'b0, "R10 swack clear", 144'(got_sw[0]), 0);
   endtask

   task automatic t_busy();
      int b0 = busy_cnt;
      activate(0, 7);
      repeat (6) @(negedge clk);
      chk(busy_cnt == b0 + 1, "R8 busy_err pulse", 144'(busy_cnt - b0), 1);
      chk(rd_cnt == 0 && !msg_valid_o, "R8 no read no message", 144'(rd_cnt), 0);
      chk(st(0) == 2'd1, "R8 status unchanged", 144'(st(0)), 1);
      for (int k = 0; k < 4; k++) pulse_ack(0);
      chk(st(0) == 2'd0, "R6 idle after four acks", 144'(st(0)), 0);
   endtask

   task automatic t_wrap();
      logic [255:0] v = '0;
      v[1:0] = 2'b11;
      dmem[9] = mk_desc(v, 15'h7FFF, 8'h38, 0, 0, 0, 96'h0, 24'h0, 16'h0);
      activate(3, 9);
      collect();
      chk(n_got == 2 && got_dest[0] == 15'h7FFF && got_dest[1] == 15'h0000,
          "R2 node id wrap", 144'({got_dest[0], got_dest[1]}), 144'({15'h7FFF, 15'h0}));
      pulse_ack(3); pulse_ack(3);
   endtask

   task automatic t_fmt();
      logic [255:0] v = '1;
      int f0;
      dmem[11] = mk_desc(v, 15'd0, 8'h38, 1, 0, 0, 96'h0, 24'h0, 16'h0);
      dmem[12] = mk_desc(v, 15'd0, 8'h37, 0, 0, 0, 96'h0, 24'h0, 16'h0);
      dmem[13] = mk_desc(v, 15'd0, 8'h38, 0, 1, 0, 96'h0, 24'h0, 16'h0);
      for (int set = 11; set <= 13; set++) begin
         f0 = fmt_cnt;
         activate(2, set);
         collect();
         chk(n_got == 0 && fmt_cnt == f0 + 1, "R4 descriptor refused",
             144'({n_got, fmt_cnt - f0}), 144'({32'd0, 32'd1}));
         chk(st(2) == 2'd0, "R4 status back to idle", 144'(st(2)), 0);
      end
   endtask

   task automatic t_tmo();
      logic [255:0] v = '0;
      v[15:0] = 16'hFFFF;
      dmem[20] = mk_desc(v, 15'd0, 8'h38, 0, 0, 0, 96'h0, 24'h0, 16'h0);
      v = '0; v[0] = 1'b1;
      dmem[21] = mk_desc(v, 15'd40, 8'h38, 0, 0, 0, 96'h0, 24'h0, 16'h0);
      activate(2, 20);
      wait_valid();
      @(negedge clk); dst_tmo_i[2] = 1'b1;
      @(negedge clk); dst_tmo_i = '0;
      @(negedge clk);
      chk(st(2) == 2'd2, "R7 destination timeout code", 144'(st(2)), 2);
      chk(!msg_valid_o && act_ready_o, "R7 sending stopped", 144'(msg_valid_o), 0);
      activate(1, 21);
      collect();
      chk(n_got == 1 && st(1) == 2'd1, "R6 waiting for ack", 144'(st(1)), 1);
      @(negedge clk); src_tmo_i[1] = 1'b1;
      @(negedge clk); src_tmo_i = '0;
      chk(st(1) == 2'd3, "R7 source timeout code", 144'(st(1)), 3);
      pulse_ack(1);
      chk(st(1) == 2'd3, "R7 ack after timeout ignored", 144'(st(1)), 3);
      activate(1, 21);
      collect();
      chk(n_got == 1 && got_dest[0] == 15'd40 && st(1) == 2'd1,
          "R5 restart from timeout", 144'(st(1)), 1);
      pulse_ack(1);
      chk(st(1) == 2'd0, "R6 idle after restart ack", 144'(st(1)), 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) dmem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_stream();
      t_busy();
      t_wrap();
      t_fmt();
      t_tmo();
      finish_run();
   end

endmodule